// File: doc/BRIEF.md
# Tree Up-Down Route Unit

This block plans the path a packet takes through a k-ary tree or fat-tree of height `LEVELS`, where the radix `RADIX` is a power of two. Each leaf has an address of `LEVELS` radix-k digits that spells the path down from the root. For a source and destination pair, the unit finds the lowest level at which the two leaves share an ancestor. The packet must climb to that ancestor and then come back down.

A request carries a source and a destination leaf address on a valid/ready handshake. The unit then emits the route one hop per cycle on a second valid/ready stream. The route starts with the parent moves. The child-port moves follow, and each of them is taken directly from the destination digits. The final hop carries a last flag. A route from a leaf to itself is reported as one marker beat that contains no moves. The unit takes the next request only after the final hop of the current route has been accepted.

Top module: `tree_route_unit`

## Requirements
- R1: Digit j of an address occupies bits [j*log2(RADIX) +: log2(RADIX)]. Digit LEVELS-1 selects the child of the root, and digit 0 selects the leaf.
- R2: When source and destination differ, let t be the highest digit index at which they differ. The route then contains exactly t+1 parent beats, and they come before any child beat.
- R3: A parent beat has the top bit of `hop_port` at 1 and all of its lower bits at 0.
- R4: After the parent beats come exactly t+1 child beats. Each has the top bit of `hop_port` at 0. Their low bits carry the destination digits t, t-1, down to 0, in that order.
- R5: `hop_last` is 1 on the final child beat of a route and 0 on every other beat.
- R6: When source equals destination, the route is a single beat with `hop_empty`=1, `hop_last`=1 and `hop_port`=0. Every other beat has `hop_empty`=0.
- R7: While `hop_valid` is 1 and `hop_ready` is 0, the values of `hop_valid`, `hop_port`, `hop_last` and `hop_empty` do not change.
- R8: `req_ready` drops in the cycle after a request is accepted. It rises again in the cycle after the final beat is accepted. Requests presented while it is low have no effect on the route in progress.
- R9: After reset, `req_ready` is 1 and `hop_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; a request is taken when this and req_valid are both 1 |
| req_src | input | LEVELS*log2(RADIX) | Source leaf address |
| req_dst | input | LEVELS*log2(RADIX) | Destination leaf address |
| hop_valid | output | 1 | Hop beat present |
| hop_ready | input | 1 | Consumer takes the hop beat |
| hop_port | output | log2(RADIX)+1 | Hop code: top bit 1 means parent; top bit 0 means child, with the child index in the low bits |
| hop_last | output | 1 | Final beat of the route |
| hop_empty | output | 1 | Marker beat for a route from a leaf to itself |

## Verification
A wrong turnaround level shows up within the first few beats. The number of parent beats comes out different from t+1, and a child digit is taken from the wrong position. A down-index register that is off by one puts a wrong child code on the first child beat and moves the last flag. A phase register that gets stuck keeps `req_ready` low after the final beat. A phase register that leaks under backpressure changes the held beat in the very next stalled cycle.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SELF = 2'd1,
      PH_UP   = 2'd2,
      PH_DOWN = 2'd3
   } phase_e;
endpackage

// File: rtl/tree_lca_detect.sv
module tree_lca_detect #(
   parameter int RADIX  = 4,
   parameter int LEVELS = 3
) (
   input  logic [LEVELS*$clog2(RADIX)-1:0] src,
   input  logic [LEVELS*$clog2(RADIX)-1:0] dst,
   output logic                            same,
   output logic [$clog2(LEVELS)-1:0]       top_idx
);
   localparam int DW    = $clog2(RADIX);
   localparam int IDX_W = $clog2(LEVELS);

   logic [LEVELS-1:0] dig_diff;

   // one comparator per digit position
   for (genvar j = 0; j < LEVELS; j++) begin : g_dig
      assign dig_diff[j] = |(src[j*DW +: DW] ^ dst[j*DW +: DW]);
   end

   // ascending scan: the highest differing digit wins
   always_comb begin
      top_idx = '0;
      for (int j = 0; j < LEVELS; j++) begin
         if (dig_diff[j]) top_idx = IDX_W'(j);
      end
   end

   assign same = ~|dig_diff;
endmodule

// File: rtl/tree_hop_seq.sv
module tree_hop_seq
   import tree_route_pkg::*;
#(
   parameter int RADIX  = 4,
   parameter int LEVELS = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic                            start_self,
   input  logic [$clog2(LEVELS)-1:0]       start_lvl,
   input  logic [LEVELS*$clog2(RADIX)-1:0] start_dst,
   input  logic                            hop_ready,
   output logic                            busy,
   output logic                            hop_valid,
   output logic [$clog2(RADIX):0]          hop_port,
   output logic                            hop_last,
   output logic                            hop_empty
);
   localparam int DW    = $clog2(RADIX);
   localparam int AW    = LEVELS*DW;
   localparam int IDX_W = $clog2(LEVELS);
   localparam int CNT_W = $clog2(LEVELS+1);

   phase_e            phase;
   logic [CNT_W-1:0]  up_left;
   logic [IDX_W-1:0]  down_idx;
   logic [AW-1:0]     dst_q;
   logic [DW-1:0]     cur_dig;
   logic              fire;

   always_comb begin
      cur_dig = '0;
      for (int j = 0; j < LEVELS; j++) begin
         if (IDX_W'(j) == down_idx) cur_dig = dst_q[j*DW +: DW];
      end
   end

   assign busy      = (phase != PH_IDLE);
   assign hop_valid = busy;
   assign fire      = hop_valid && hop_ready;
   assign hop_empty = (phase == PH_SELF);
   assign hop_last  = (phase == PH_SELF) || ((phase == PH_DOWN) && (down_idx == '0));

   always_comb begin
      unique case (phase)
         PH_UP:   hop_port = {1'b1, {DW{1'b0}}};
         PH_DOWN: hop_port = {1'b0, cur_dig};
         default: hop_port = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         up_left  <= '0;
         down_idx <= '0;
         dst_q    <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               dst_q    <= start_dst;
               down_idx <= start_lvl;
               up_left  <= CNT_W'(start_lvl) + CNT_W'(1);
               phase    <= start_self ? PH_SELF : PH_UP;
            end
            PH_SELF: if (fire) phase <= PH_IDLE;
            PH_UP: if (fire) begin
               up_left <= up_left - CNT_W'(1);
               if (up_left == CNT_W'(1)) phase <= PH_DOWN;
            end
            PH_DOWN: if (fire) begin
               if (down_idx == '0) phase <= PH_IDLE;
               else down_idx <= down_idx - IDX_W'(1);
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit #(
   parameter int RADIX  = 4,
   parameter int LEVELS = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic [LEVELS*$clog2(RADIX)-1:0] req_src,
   input  logic [LEVELS*$clog2(RADIX)-1:0] req_dst,
   output logic                            hop_valid,
   input  logic                            hop_ready,
   output logic [$clog2(RADIX):0]          hop_port,
   output logic                            hop_last,
   output logic                            hop_empty
);
   localparam int IDX_W = $clog2(LEVELS);

   if (RADIX < 2 || (RADIX & (RADIX - 1)) != 0) begin : g_bad_radix
      $error("tree_route_unit: RADIX must be a power of two, at least 2");
   end
   if (LEVELS < 2) begin : g_bad_levels
      $error("tree_route_unit: LEVELS must be at least 2");
   end

   logic             busy;
   logic             same;
   logic [IDX_W-1:0] top_idx;

   assign req_ready = !busy;

   tree_lca_detect #(.RADIX(RADIX), .LEVELS(LEVELS)) u_lca (
      .src     (req_src),
      .dst     (req_dst),
      .same    (same),
      .top_idx (top_idx)
   );

   tree_hop_seq #(.RADIX(RADIX), .LEVELS(LEVELS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (req_valid && req_ready),
      .start_self (same),
      .start_lvl  (top_idx),
      .start_dst  (req_dst),
      .hop_ready  (hop_ready),
      .busy       (busy),
      .hop_valid  (hop_valid),
      .hop_port   (hop_port),
      .hop_last   (hop_last),
      .hop_empty  (hop_empty)
   );
endmodule

// File: rtl/tree_route_unit_chk.sv
module tree_route_unit_chk #(
   parameter int RADIX = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_ready,
   input logic                   hop_valid,
   input logic                   hop_ready,
   input logic [$clog2(RADIX):0] hop_port,
   input logic                   hop_last,
   input logic                   hop_empty
);
   localparam int PW = $clog2(RADIX) + 1;

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hop_valid && !hop_ready |=> hop_valid && $stable(hop_port)
                                 && $stable(hop_last) && $stable(hop_empty));

   p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> hop_valid && !req_ready);

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hop_valid && hop_ready && hop_last |=> req_ready && !hop_valid);

   p_empty_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hop_valid && hop_empty |-> hop_last && hop_port == '0);

   p_down_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hop_valid && hop_ready && !hop_empty && !hop_port[PW-1] && !hop_last
      |=> hop_valid && !hop_port[PW-1]);

   p_last_child_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hop_valid && hop_last && !hop_empty |-> !hop_port[PW-1]);

   p_up_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hop_valid && hop_port[PW-1] |-> hop_port[PW-2:0] == '0 && !hop_last);
endmodule

bind tree_route_unit tree_route_unit_chk #(.RADIX(RADIX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .hop_valid (hop_valid),
   .hop_ready (hop_ready),
   .hop_port  (hop_port),
   .hop_last  (hop_last),
   .hop_empty (hop_empty)
);

// File: tb/tree_route_unit_test.sv
`timescale 1ns/1ps
module tree_route_unit_test;
   localparam int RADIX  = 4;
   localparam int LEVELS = 3;
   localparam int DW     = $clog2(RADIX);
   localparam int AW     = LEVELS*DW;
   localparam int PW     = DW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_src = '0;
   logic [AW-1:0] req_dst = '0;
   logic          hop_valid;
   logic          hop_ready = 1'b0;
   logic [PW-1:0] hop_port;
   logic          hop_last;
   logic          hop_empty;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   tree_route_unit #(.RADIX(RADIX), .LEVELS(LEVELS)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_src(req_src), .req_dst(req_dst), .hop_valid(hop_valid),
      .hop_ready(hop_ready), .hop_port(hop_port), .hop_last(hop_last),
      .hop_empty(hop_empty)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int turn_level(input logic [AW-1:0] s, input logic [AW-1:0] d);
      int t = -1;
      for (int j = 0; j < LEVELS; j++)
         if (s[j*DW +: DW] != d[j*DW +: DW]) t = j;
      return t;
   endfunction

   // drive one request and check every beat of the route
   task automatic run_route(input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input bit stall, input bit poke);
      int t = turn_level(s, d);
      int n = (t < 0) ? 1 : 2*(t+1);
      int idx = 0, cyc = 0, ups = 0;
      bit have_prev = 1'b0;
      logic [PW-1:0] prev_port = '0;
      logic prev_last = 1'b0, prev_empty = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 idle before request", int'(req_ready), 1);
      req_src = s; req_dst = d; req_valid = 1'b1; hop_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R8 busy after accept", int'(req_ready), 0);
      if (poke) begin
         req_valid = 1'b1; req_src = ~s; req_dst = ~d;
      end
      while (idx < n && cyc < 100) begin
         logic [PW-1:0] e_port;
         bit e_last, e_empty, rdy;
         if (cyc == 1) req_valid = 1'b0;
         rdy = stall ? ((cyc % 3) != 2) : 1'b1;
         hop_ready = rdy;
         if (have_prev)
            chk(hop_valid && hop_port == prev_port && hop_last == prev_last
                && hop_empty == prev_empty, "R7 held beat", int'(hop_port), int'(prev_port));
         if (t < 0) begin
            e_port = '0; e_last = 1'b1; e_empty = 1'b1;
         end else if (idx <= t) begin
            e_port = PW'(1) << DW; e_last = 1'b0; e_empty = 1'b0;
         end else begin
            int pos = t - (idx - (t+1));
            e_port = {1'b0, d[pos*DW +: DW]}; e_last = (pos == 0); e_empty = 1'b0;
         end
         if (!hop_valid) begin
            chk(1'b0, "R8 hop_valid during route", 0, 1);
         end else if (rdy) begin
            if (t < 0)
               chk(hop_empty && hop_last && hop_port == '0, "R6 self route",
                   int'(hop_port), 0);
            else if (idx <= t)
               chk(hop_port == e_port, "R3 parent code", int'(hop_port), int'(e_port));
            else
               chk(hop_port == e_port, "R4 child digit", int'(hop_port), int'(e_port));
            if (t >= 0) begin
               chk(hop_last == e_last, "R5 last flag", int'(hop_last), int'(e_last));
               chk(hop_empty == 1'b0, "R6 empty clear", int'(hop_empty), 0);
            end
            if (hop_port[PW-1]) ups++;
            idx++;
            have_prev = 1'b0;
         end else begin
            prev_port = hop_port; prev_last = hop_last; prev_empty = hop_empty;
            have_prev = 1'b1;
         end
         @(negedge clk);
         cyc++;
      end
      hop_ready = 1'b0;
      req_valid = 1'b0;
      chk(idx == n, "R2 route length", idx, n);
      if (t >= 0) chk(ups == t+1, "R2 parent count", ups, t+1);
      chk(req_ready == 1'b1 && hop_valid == 1'b0, "R8 idle after last",
          int'(req_ready), 1);
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
      chk(hop_valid == 1'b0, "R9 reset valid", int'(hop_valid), 0);
      rst_n = 1'b1;
   endtask

   // R6: same leaf
   task automatic test_self();
      run_route(6'h2D, 6'h2D, 1'b0, 1'b0);
      run_route(6'h00, 6'h00, 1'b1, 1'b0);
   endtask

   // R1 R2: differing digit position sets the turnaround level
   task automatic test_levels();
      run_route(6'h10, 6'h13, 1'b0, 1'b0);  // digit 0 only: 1 up, 1 down
      run_route(6'h05, 6'h09, 1'b0, 1'b0);  // digit 1
      run_route(6'h05, 6'h36, 1'b0, 1'b0);  // digit 2
      run_route(6'h3F, 6'h00, 1'b0, 1'b0);
   endtask

   // R7: backpressure
   task automatic test_stall();
      run_route(6'h01, 6'h2E, 1'b1, 1'b0);
      run_route(6'h22, 6'h27, 1'b1, 1'b0);
   endtask

   // R8: requests while busy are ignored
   task automatic test_busy();
      run_route(6'h04, 6'h39, 1'b0, 1'b1);
      run_route(6'h11, 6'h12, 1'b1, 1'b1);
   endtask

   // R4 R5: every destination from one source
   task automatic test_sweep();
      for (int k = 0; k < (1 << AW); k++)
         run_route(6'h1B, AW'(k), k[0], 1'b0);
   endtask

   initial begin
      test_reset();
      test_self();
      test_levels();
      test_stall();
      test_busy();
      test_sweep();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule